// File: doc/BRIEF.md
# Vector Integer Compare-to-Mask Unit

This block evaluates one vector integer compare against a 5-bit immediate taken from the instruction word. It produces a packed mask with one bit per element. The source register is a flat vector of `VLEN` bits, split into elements of 8, 16, 32 or 64 bits according to the current element width. Each enabled element is compared with the immediate, after the immediate is sign-extended to that width, and the outcome goes into result bit *i*. Every other destination bit keeps the value of the old destination mask.

An operation is offered on `in_valid`. The unit never applies back-pressure: `in_ready` is held high, so every cycle with `in_valid` high starts one operation. There is no ready on the result side. On the clock edge after acceptance the unit does one of two things:
- It presents the new mask on `vd_new` and pulses `done` for one cycle. `done` doubles as the request to clear the element start index.
- It pulses `illegal` if the mask configuration is forbidden.

`vd_new` holds its value until the next successful operation.

Top module: `vcmp_mask_unit`

## Requirements
- R1: The mask-select bit is `insn[25]`, the immediate is `insn[19:15]` and the destination register index is `insn[11:7]`.
- R2: The immediate is sign-extended to the element width for every compare, including the unsigned ones. For example, immediate 5'h1F is the all-ones value for an unsigned compare.
- R3: `op` selects the compare of element against immediate: 0 equal, 1 not equal, 2 unsigned less-or-equal, 3 signed less-or-equal, 4 unsigned greater-than, 5 signed greater-than.
- R4: `sew` 0/1/2/3 selects element widths 8/16/32/64. There are `VLEN/width` elements, and element *i* occupies `vs2_data[i*width +: width]`.
- R5: The compare outcome of element *i* is written to bit *i* of `vd_new`.
- R6: When `insn[25]` is 0, element *i* is enabled only if `v0_mask[i]` is 1. A disabled element keeps bit *i* of `vd_old`.
- R7: When `insn[25]` is 1, every element with index below `vl` is enabled.
- R8: Bit positions at or above `vl`, and positions at or above the element count, keep the corresponding bit of `vd_old`.
- R9: An operation accepted on a clock edge shows its mask on `vd_new` together with a one-cycle `done` pulse after that same edge.
- R10: If `insn[25]` is 0 and `insn[11:7]` is 0, the operation is illegal. `illegal` pulses for one cycle, `done` stays low, and `vd_new` is unchanged.
- R11: `op` codes 6 and 7 write 0 to every enabled element position.
- R12: `in_ready` is always 1. After reset, `done`, `illegal` and `vd_new` are 0. Without an accepted operation, `done` and `illegal` are 0 and `vd_new` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_ready | output | 1 | Always 1; no back-pressure |
| insn | input | 32 | Instruction word holding the mask-select, immediate and destination fields |
| op | input | 3 | Compare function code |
| sew | input | 2 | Element width code |
| vl | input | $clog2(VLEN)+1 | Active element count |
| vs2_data | input | VLEN | Source register contents |
| v0_mask | input | VLEN | Mask register contents |
| vd_old | input | VLEN | Prior destination mask |
| vd_new | output | VLEN | Resulting destination mask |
| done | output | 1 | One-cycle completion pulse; also requests that the start index be cleared |
| illegal | output | 1 | One-cycle illegal-configuration pulse |

## Verification
Every result is due exactly one clock edge after the edge that accepted the operation, with no result-side stalls. The bench drives stimulus on the falling edge and samples all three outputs on the next falling edge, which lies after the single register stage. A behavioural model advances by one operation per cycle and is compared on every clock, idle cycles included. This also catches a result or pulse that arrives one cycle early or late, or lingers for a second cycle.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [2:0] {
    CMP_EQ   = 3'd0,
    CMP_NE   = 3'd1,
    CMP_LEU  = 3'd2,
    CMP_LE   = 3'd3,
    CMP_GTU  = 3'd4,
    CMP_GT   = 3'd5,
    CMP_RSV6 = 3'd6,
    CMP_RSV7 = 3'd7
  } cmp_op_e;

  localparam int SEW_CODES = 4;
  localparam int IMM_W     = 5;

  function automatic logic cmp_pick(cmp_op_e op, logic eq, logic ltu, logic lts);
    case (op)
      CMP_EQ:  return eq;
      CMP_NE:  return !eq;
      CMP_LEU: return ltu | eq;
      CMP_LE:  return lts | eq;
      CMP_GTU: return !(ltu | eq);
      CMP_GT:  return !(lts | eq);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/vcmp_elem_cmp.sv
module vcmp_elem_cmp
  import vcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] elem,
  input  logic [W-1:0] imm,
  input  cmp_op_e      op,
  output logic         hit
);
  logic eq, ltu, lts;

  always_comb begin
    eq  = (elem == imm);
    ltu = (elem < imm);
    lts = ($signed(elem) < $signed(imm));
    hit = cmp_pick(op, eq, ltu, lts);
  end
endmodule

// File: rtl/vcmp_sew_bank.sv
module vcmp_sew_bank
  import vcmp_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int W    = 8,
  localparam int NE  = VLEN / W
) (
  input  logic [VLEN-1:0]  src,
  input  logic [IMM_W-1:0] simm,
  input  cmp_op_e          op,
  output logic [NE-1:0]    hits
);
  logic [W-1:0] imm_ext;

  // immediate widened by sign for all compares
  assign imm_ext = {{(W-IMM_W){simm[IMM_W-1]}}, simm};

  for (genvar e = 0; e < NE; e++) begin : g_elem
    vcmp_elem_cmp #(.W(W)) u_cmp (
      .elem (src[e*W +: W]),
      .imm  (imm_ext),
      .op   (op),
      .hit  (hits[e])
    );
  end
endmodule

// File: rtl/vcmp_mask_merge.sv
module vcmp_mask_merge #(
  parameter int VLEN = 128,
  localparam int VLW = $clog2(VLEN) + 1
) (
  input  logic [VLEN-1:0] hits,
  input  logic [VLEN-1:0] old_mask,
  input  logic [VLEN-1:0] v0,
  input  logic            unmasked,
  input  logic [VLW-1:0]  vl,
  input  logic [VLW-1:0]  nelem,
  output logic [VLEN-1:0] en,
  output logic [VLEN-1:0] merged
);
  always_comb begin
    for (int i = 0; i < VLEN; i++) begin
      en[i]     = (VLW'(i) < vl) && (VLW'(i) < nelem) && (unmasked || v0[i]);
      merged[i] = en[i] ? hits[i] : old_mask[i];
    end
  end
endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit
  import vcmp_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int VLW = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     insn,
  input  logic [2:0]      op,
  input  logic [1:0]      sew,
  input  logic [VLW-1:0]  vl,
  input  logic [VLEN-1:0] vs2_data,
  input  logic [VLEN-1:0] v0_mask,
  input  logic [VLEN-1:0] vd_old,
  output logic [VLEN-1:0] vd_new,
  output logic            done,
  output logic            illegal
);
  // R1 field positions
  logic             f_vm;
  logic [IMM_W-1:0] f_simm;
  logic [4:0]       f_vd;
  assign f_vm   = insn[25];
  assign f_simm = insn[19:15];
  assign f_vd   = insn[11:7];

  cmp_op_e op_e;
  assign op_e = cmp_op_e'(op);

  logic [VLEN-1:0] hits_by_sew [SEW_CODES];

  for (genvar g = 0; g < SEW_CODES; g++) begin : g_sew
    localparam int W  = 8 << g;
    localparam int NE = VLEN / W;
    logic [NE-1:0] bank_hits;
    vcmp_sew_bank #(.VLEN(VLEN), .W(W)) u_bank (
      .src  (vs2_data),
      .simm (f_simm),
      .op   (op_e),
      .hits (bank_hits)
    );
    assign hits_by_sew[g] = {{(VLEN-NE){1'b0}}, bank_hits};
  end

  logic [VLEN-1:0] sel_hits, en_mask, merged;
  logic [VLW-1:0]  nelem;
  assign sel_hits = hits_by_sew[sew];
  assign nelem    = VLW'(VLEN >> (3 + sew));

  vcmp_mask_merge #(.VLEN(VLEN)) u_merge (
    .hits     (sel_hits),
    .old_mask (vd_old),
    .v0       (v0_mask),
    .unmasked (f_vm),
    .vl       (vl),
    .nelem    (nelem),
    .en       (en_mask),
    .merged   (merged)
  );

  logic bad_cfg;
  assign bad_cfg  = !f_vm && (f_vd == 5'd0);
  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vd_new  <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= in_valid && !bad_cfg;
      illegal <= in_valid && bad_cfg;
      if (in_valid && !bad_cfg) vd_new <= merged;
    end
  end

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && illegal));

  // R10
  bad_cfg_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !insn[25] && insn[11:7] == 5'd0) |=> (illegal && !done && $stable(vd_new)));

  // R9
  legal_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (insn[25] || insn[11:7] != 5'd0)) |=> done);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && !illegal && $stable(vd_new)));

  // R8
  keep_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad_cfg) |=> (((vd_new ^ $past(vd_old)) & ~$past(en_mask)) == '0));

  // R12
  ready_high_chk: assert property (@(posedge clk) in_ready);
endmodule

// File: tb/test_vcmp_mask_unit.sv
`timescale 1ns/1ps
module test_vcmp_mask_unit;
  localparam int VLEN = 128;
  localparam int VLW  = $clog2(VLEN) + 1;

  logic clk = 0, rst_n = 0, in_valid = 0, in_ready, done, illegal;
  logic [31:0] insn = '0;
  logic [2:0] op = '0;
  logic [1:0] sew = '0;
  logic [VLW-1:0] vl = '0;
  logic [VLEN-1:0] vs2_data = '0, v0_mask = '0, vd_old = '0, vd_new;

  int n_vec = 0, n_bad = 0;
  string cur_req = "R12 reset";
  logic exp_done = 0, exp_ill = 0;
  logic [VLEN-1:0] exp_vd = '0;

  always #2 clk = ~clk;

  vcmp_mask_unit #(.VLEN(VLEN)) i_vcmp_mask_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .op(op), .sew(sew), .vl(vl), .vs2_data(vs2_data),
    .v0_mask(v0_mask), .vd_old(vd_old), .vd_new(vd_new),
    .done(done), .illegal(illegal));

  function automatic logic [VLEN-1:0] model(logic [2:0] f, logic [1:0] s, int len,
      logic vmb, logic [4:0] imm, logic [VLEN-1:0] src, logic [VLEN-1:0] m0,
      logic [VLEN-1:0] old);
    logic [VLEN-1:0] r = old;
    int w = 8 << s;
    logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] iu = {{59{imm[4]}}, imm} & msk;
    longint is = $signed({{59{imm[4]}}, imm});
    for (int i = 0; i < VLEN / w; i++) begin
      if (i < len && (vmb || m0[i])) begin
        logic [63:0] eu = 64'(src >> (i * w)) & msk;
        longint es = $signed(eu[w-1] ? (eu | ~msk) : eu);
        case (f)
          0: r[i] = (eu == iu);
          1: r[i] = (eu != iu);
          2: r[i] = (eu <= iu);
          3: r[i] = (es <= is);
          4: r[i] = (eu > iu);
          5: r[i] = (es > is);
          default: r[i] = 1'b0;
        endcase
      end
    end
    return r;
  endfunction

  task automatic compare_now();
    n_vec++;
    if (done !== exp_done || illegal !== exp_ill || vd_new !== exp_vd || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: done/illegal/ready/vd_new = %0b/%0b/%0b/%h expected %0b/%0b/1/%h",
               cur_req, done, illegal, in_ready, vd_new, exp_done, exp_ill, exp_vd);
    end
  endtask

  // one cycle: check outputs of previous edge, drive next stimulus, predict
  task automatic step(string req, logic v, logic [2:0] f, logic [1:0] s, int len,
      logic vmb, logic [4:0] imm, logic [4:0] vdi,
      logic [VLEN-1:0] src, logic [VLEN-1:0] m0, logic [VLEN-1:0] old);
    @(negedge clk);
    compare_now();
    cur_req  = req;
    in_valid = v; op = f; sew = s; vl = VLW'(len);
    insn     = {6'd0, vmb, 5'd3, imm, 3'd0, vdi, 7'h57};
    vs2_data = src; v0_mask = m0; vd_old = old;
    if (!v) begin
      exp_done = 0; exp_ill = 0;
    end else if (!vmb && vdi == 5'd0) begin
      exp_done = 0; exp_ill = 1;
    end else begin
      exp_done = 1; exp_ill = 0;
      exp_vd = model(f, s, len, vmb, imm, src, m0, old);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] a;
    repeat (3) begin @(negedge clk); compare_now(); end
    @(negedge clk); rst_n = 1;
    // R2: unsigned <= all-ones immediate is true everywhere
    step("R2 leu imm -1", 1, 2, 0, 16, 1, 5'h1f, 5, rnd(), '0, '0);
    step("R2 gtu imm -1", 1, 4, 0, 16, 1, 5'h1f, 5, rnd(), '0, '1);
    // R3: each code over several widths
    for (int f = 0; f < 6; f++)
      for (int s = 0; s < 4; s++) begin
        a = rnd();
        a[15:0] = 16'hFFF0; a[23:16] = 8'h0F;
        step("R3 op sweep", 1, 3'(f), 2'(s), 128, 1, 5'(f * 5 + 2), 7, a, '0, rnd());
      end
    // R4/R5: element boundaries, equality against -16 on each width
    step("R4 sew64 eq", 1, 0, 3, 2, 1, 5'h10, 1, {64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_00F0}, '0, '0);
    step("R5 sew32 eq", 1, 0, 2, 4, 1, 5'h10, 1, {32'hFFFFFFF0, 32'h0, 32'hFFFFFFF0, 32'hF0}, '0, '0);
    // R6: masked by v0
    step("R6 masked", 1, 1, 0, 16, 0, 5'h3, 2, rnd(), 128'h5A5A, rnd());
    step("R6 masked none", 1, 1, 1, 8, 0, 5'h3, 2, rnd(), '0, rnd());
    // R7 unmasked full length
    step("R7 unmasked", 1, 5, 1, 8, 1, 5'h0, 9, rnd(), '0, rnd());
    // R8 vl boundaries
    step("R8 vl=0", 1, 1, 0, 0, 1, 5'h0, 4, rnd(), '1, rnd());
    step("R8 vl=3", 1, 1, 0, 3, 1, 5'h0, 4, rnd(), '1, rnd());
    step("R8 vl over count", 1, 1, 2, 200, 1, 5'h0, 4, rnd(), '1, rnd());
    // R10 illegal, then R12 idle hold
    step("R10 illegal", 1, 0, 0, 16, 0, 5'h0, 0, rnd(), '1, rnd());
    step("R12 idle", 0, 0, 0, 16, 1, 5'h0, 1, rnd(), '1, rnd());
    step("R12 idle", 0, 0, 0, 16, 1, 5'h0, 1, rnd(), '1, rnd());
    // R1 vd nonzero with vm=0 is legal
    step("R1 vd field", 1, 0, 0, 16, 0, 5'h0, 16, '0, '1, '0);
    // R11 reserved codes
    step("R11 code6", 1, 6, 0, 16, 1, 5'h0, 3, '0, '0, '1);
    step("R11 code7", 1, 7, 1, 8, 1, 5'h0, 3, '0, '0, '1);
    // R9 back-to-back and random mix
    for (int k = 0; k < 600; k++)
      step("R9 random", ($urandom % 4) != 0, 3'($urandom), 2'($urandom),
           int'($urandom % 140), 1'($urandom), 5'($urandom), 5'($urandom % 3),
           rnd(), rnd(), rnd());
    step("R12 idle end", 0, 0, 0, 0, 1, 5'h0, 1, '0, '0, '0);
    @(negedge clk); compare_now();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule